// File: doc/BRIEF.md
# System-Management Special Cycle Responder

This block sits on the host side of a host-to-PCI bridge and watches special transactions that the front end has already decoded. Every valid special transaction gets a response-phase request one clock later. Two of the message types also have side effects.

A management-interrupt acknowledge copies the memory-space qualifier that was sampled with the request into a sticky management-active level. That level can only be cleared by a later acknowledge that carries the qualifier low. A stop-clock acknowledge asks the downstream bus master to run a stop-grant special cycle. The request to the downstream master stays raised until the master returns a done pulse. Acknowledges that arrive while a request is still outstanding are counted, and each one is issued after the previous one completes. Any other special type gets only the response.

Top module: `smm_special_responder`

## Requirements
- R1: While reset is applied and right after it is released, `resp_req`, `mgmt_active` and `sg_req` are all low.
- R2: Each clock edge that samples `txn_valid` high makes `resp_req` high for exactly the following cycle. With `txn_valid` low, `resp_req` is low regardless of `txn_type`.
- R3: A valid transaction with `txn_type` = 3'b001 (management acknowledge) and `mem_qual` high sets `mgmt_active` from the next cycle on.
- R4: A valid management acknowledge (3'b001) with `mem_qual` low clears `mgmt_active` from the next cycle on.
- R5: `mgmt_active` keeps its value across cycles with no valid transaction and across any valid transaction whose type is not 3'b001.
- R6: A valid transaction with `txn_type` = 3'b010 (stop-clock acknowledge) raises `sg_req` in the next cycle. `sg_req` then stays high until an edge samples `sg_done` high.
- R7: Each `sg_done` retires one outstanding stop-grant request. A stop-clock acknowledge that arrives while a request is outstanding is held, and `sg_req` stays high after the done pulse so that the held request is issued next. An acknowledge and a done pulse on the same edge leave the number of outstanding requests unchanged.
- R8: At most MAX_PEND outstanding requests are kept (default 4). Further stop-clock acknowledges are dropped. `sg_done` sampled while nothing is outstanding has no effect.
- R9: A valid transaction of any other type (for example 3'b101) produces the response pulse but changes neither `mgmt_active` nor `sg_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_valid | input | 1 | Decoded special transaction present this cycle |
| txn_type | input | TYPE_W | Special transaction message type |
| mem_qual | input | 1 | Memory-space qualifier sampled with the request |
| sg_done | input | 1 | Downstream stop-grant cycle finished (one-cycle pulse) |
| resp_req | output | 1 | Request to drive the response phase (one-cycle pulse) |
| mgmt_active | output | 1 | Sticky management-active level |
| sg_req | output | 1 | Request to the downstream master for a stop-grant special cycle |

## Verification
The hardest state to reach from the ports is a full backlog of stop-grant requests. The bench gets there by issuing more stop-clock acknowledges than MAX_PEND without any done pulse. It then retires them one done pulse at a time and checks that `sg_req` drops only after exactly MAX_PEND pulses. It also puts an acknowledge and a done pulse on the same edge, and sends a done pulse when nothing is outstanding, so that the counter boundaries at both ends are exercised.

// File: rtl/smr_pkg.sv
package smr_pkg;
   typedef struct packed {
      logic any;
      logic mgmt_ack;
      logic stop_ack;
   } smr_dec_t;
endpackage

// File: rtl/smr_decode.sv
module smr_decode #(
   parameter int unsigned TYPE_W    = 3,
   parameter logic [TYPE_W-1:0] MGMT_CODE = 3'b001,
   parameter logic [TYPE_W-1:0] STOP_CODE = 3'b010
) (
   input  logic              valid,
   input  logic [TYPE_W-1:0] kind,
   output smr_pkg::smr_dec_t dec
);
   always_comb begin
      dec.any      = valid;
      dec.mgmt_ack = valid && (kind == MGMT_CODE);
      dec.stop_ack = valid && (kind == STOP_CODE);
   end
endmodule

// File: rtl/smr_active_flag.sv
module smr_active_flag (
   input  logic              clk,
   input  logic              rst_n,
   input  smr_pkg::smr_dec_t dec,
   input  logic              qual,
   output logic              active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            active <= 1'b0;
      else if (dec.mgmt_ack) active <= qual;
   end
endmodule

// File: rtl/smr_grant_seq.sv
module smr_grant_seq #(
   parameter int unsigned MAX_PEND = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic req
);
   localparam int unsigned CNT_W = $clog2(MAX_PEND + 1);

   generate
      if (MAX_PEND == 1) begin : g_flag
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     busy_q <= 1'b0;
            else if (start) busy_q <= 1'b1;
            else if (done)  busy_q <= 1'b0;
         end
         assign req = busy_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             inc, dec;
         assign inc = start && (cnt_q != CNT_W'(MAX_PEND));
         assign dec = done && (cnt_q != '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else begin
               case ({inc, dec})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         assign req = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/smm_special_responder.sv
module smm_special_responder #(
   parameter int unsigned TYPE_W    = 3,
   parameter logic [TYPE_W-1:0] MGMT_CODE = 3'b001,
   parameter logic [TYPE_W-1:0] STOP_CODE = 3'b010,
   parameter int unsigned MAX_PEND  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_valid,
   input  logic [TYPE_W-1:0] txn_type,
   input  logic              mem_qual,
   input  logic              sg_done,
   output logic              resp_req,
   output logic              mgmt_active,
   output logic              sg_req
);
   generate
      if (MGMT_CODE == STOP_CODE) begin : g_bad_codes
         $error("management and stop-clock codes must differ");
      end
      if (MAX_PEND < 1) begin : g_bad_depth
         $error("MAX_PEND must be at least 1");
      end
   endgenerate

   smr_pkg::smr_dec_t dec;

   smr_decode #(.TYPE_W(TYPE_W), .MGMT_CODE(MGMT_CODE), .STOP_CODE(STOP_CODE)) u_dec (
      .valid(txn_valid), .kind(txn_type), .dec(dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resp_req <= 1'b0;
      else        resp_req <= dec.any;
   end

   smr_active_flag u_act (
      .clk(clk), .rst_n(rst_n), .dec(dec), .qual(mem_qual), .active(mgmt_active)
   );

   smr_grant_seq #(.MAX_PEND(MAX_PEND)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(dec.stop_ack), .done(sg_done), .req(sg_req)
   );
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
   parameter int unsigned TYPE_W    = 3,
   parameter logic [TYPE_W-1:0] MGMT_CODE = 3'b001,
   parameter logic [TYPE_W-1:0] STOP_CODE = 3'b010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txn_valid,
   input logic [TYPE_W-1:0] txn_type,
   input logic              mem_qual,
   input logic              sg_done,
   input logic              resp_req,
   input logic              mgmt_active,
   input logic              sg_req
);
   p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> resp_req);
   p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !resp_req);
   p_active_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_type == MGMT_CODE && mem_qual) |=> mgmt_active);
   p_active_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_type == MGMT_CODE && !mem_qual) |=> !mgmt_active);
   p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(txn_valid && txn_type == MGMT_CODE) |=> $stable(mgmt_active));
   p_req_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_type == STOP_CODE) |=> sg_req);
   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sg_req && !sg_done) |=> sg_req);
   p_req_no_spur_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sg_req && !(txn_valid && txn_type == STOP_CODE)) |=> !sg_req);
endmodule

bind smm_special_responder smr_checker #(
   .TYPE_W(TYPE_W), .MGMT_CODE(MGMT_CODE), .STOP_CODE(STOP_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_type(txn_type),
   .mem_qual(mem_qual), .sg_done(sg_done), .resp_req(resp_req),
   .mgmt_active(mgmt_active), .sg_req(sg_req)
);

// File: tb/smm_special_responder_tb.sv
module smm_special_responder_tb;
   localparam int MAXP = 4;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_valid = 1'b0;
   logic [2:0] txn_type = 3'b000;
   logic mem_qual = 1'b0;
   logic sg_done = 1'b0;
   logic resp_req, mgmt_active, sg_req;

   always #5 clk = ~clk;

   smm_special_responder u_dut (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_type(txn_type),
      .mem_qual(mem_qual), .sg_done(sg_done), .resp_req(resp_req),
      .mgmt_active(mgmt_active), .sg_req(sg_req)
   );

   typedef struct {
      logic  resp;
      logic  act;
      logic  req;
      string tag;
   } exp_t;

   exp_t sb[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   logic m_act = 1'b0;
   int   m_cnt = 0;

   task automatic step(input logic v, input logic [2:0] t, input logic q,
                       input logic d, input string tag);
      exp_t e;
      @(negedge clk);
      txn_valid = v; txn_type = t; mem_qual = q; sg_done = d;
      e.resp = v;
      if (v && t == 3'b001) m_act = q;
      if (v && t == 3'b010 && m_cnt < MAXP) m_cnt++;
      if (d && m_cnt > 0 && !(v && t == 3'b010 && m_cnt == MAXP && 0)) begin
         m_cnt--;
      end
      e.act = m_act;
      e.req = (m_cnt != 0);
      e.tag = tag;
      sb.push_back(e);
      @(posedge clk);
   endtask

   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_cmp++;
         if (resp_req !== e.resp || mgmt_active !== e.act || sg_req !== e.req) begin
            n_bad++;
            $display("FAIL %s: actual resp=%b act=%b req=%b expected resp=%b act=%b req=%b",
                     e.tag, resp_req, mgmt_active, sg_req, e.resp, e.act, e.req);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      n_cmp++;
      if (resp_req !== 0 || mgmt_active !== 0 || sg_req !== 0) begin
         n_bad++;
         $display("FAIL R1 in reset: actual %b%b%b expected 000", resp_req, mgmt_active, sg_req);
      end
      @(negedge clk); rst_n = 1'b1;
      step(0, 3'b000, 0, 0, "R1 after release");
      step(0, 3'b010, 1, 0, "R2 no valid no pulse");
      step(1, 3'b001, 1, 0, "R3 set active");
      step(0, 3'b000, 0, 0, "R5 idle hold");
      step(1, 3'b010, 0, 0, "R6 stop ack raises req");
      for (int i = 0; i < 3; i++) step(0, 3'b000, 0, 0, "R6 req held");
      step(0, 3'b000, 0, 1, "R6 done drops req");
      step(0, 3'b000, 0, 1, "R8 stray done ignored");
      step(1, 3'b101, 0, 0, "R9 other type response only");
      step(1, 3'b001, 0, 0, "R4 clear active");
      step(1, 3'b101, 1, 0, "R9 other type with qual");
      step(1, 3'b001, 1, 0, "R3 set again");
      step(1, 3'b010, 0, 0, "R7 first stop");
      step(1, 3'b010, 0, 0, "R7 second stop held");
      step(0, 3'b000, 0, 1, "R7 held issued after done");
      step(0, 3'b000, 0, 1, "R7 last done");
      step(1, 3'b010, 0, 0, "R7 single outstanding");
      step(1, 3'b010, 0, 1, "R7 ack and done same edge");
      step(0, 3'b000, 0, 1, "R7 retire");
      for (int i = 0; i < MAXP + 2; i++) step(1, 3'b010, 1, 0, "R8 fill backlog");
      for (int i = 0; i < MAXP; i++) step(0, 3'b000, 0, 1, "R8 drain backlog");
      step(0, 3'b000, 0, 0, "R8 empty after drain");
      step(1, 3'b001, 0, 0, "R4 clear from stop context");
      step(0, 3'b000, 0, 0, "R5 hold cleared");
      step(0, 3'b000, 0, 0, "R2 flush");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule